// File: doc/BRIEF.md
# Clock-Buffer Configuration Register Slave (I2C)

This block is the configuration port of a clock-distribution buffer. It is an I2C slave and receiver that watches the SCL and SDA pins, oversamples them with a fast system clock, and pulls SDA low through an open-drain enable when it acknowledges or sends a zero. It holds a small register file of seven bytes. Every bit resets to one, so all clock pairs come up enabled.

The register file has no addressing. A write names the device, sends two preamble bytes that are acknowledged and discarded, and then streams data into byte 0, byte 1 and upward. The host may stop after any complete byte. A read names the device and gets a byte count first, then every register in ascending order.

Bytes 5 and 6 carry the enable bits of six differential clock pairs. These leave the block as a parallel vector. Bytes 0 to 4 are reserved: they are stored and read back but drive nothing.

Top module: `cfgbus_top`

## Requirements
- R1: The block acknowledges only the 7-bit device address 0x6A: 8-bit address byte 0xD4 for a write and 0xD5 for a read. Any other address byte gets no acknowledge and the register file is left unchanged.
- R2: In a write, the two bytes that follow the address byte (a command code and a count) are acknowledged, and their values have no effect on which register receives data.
- R3: Write data bytes after the two preamble bytes land in registers 0, 1, 2 and so on in that order, and each one is acknowledged.
- R4: When a write ends with a stop after k complete data bytes, registers 0 to k-1 hold the new bytes and every other register keeps its old value.
- R5: A data byte beyond register 6 gets no acknowledge and is discarded.
- R6: A read returns the byte count 7 first, then registers 0 to 6, each sent MSB first while SCL is low.
- R7: After the host answers a read byte with a not-acknowledge, SDA stays released through any further SCL pulses until the next stop or start.
- R8: After reset, every register reads 0xFF, every pair enable is 1 and SDA is released.
- R9: pairEn[k] equals bit k of register 5 for k = 0..2, and pairEn[3+k] equals bit k of register 6 for k = 0..2.
- R10: A repeated start in the middle of a write keeps the data bytes already completed and begins a new address phase.
- R11: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; much faster than SCL |
| rstN | input | 1 | Synchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen on the pin |
| sdaIn | input | 1 | Serial data line as seen on the pin |
| sdaOe | output | 1 | Open-drain enable; 1 pulls SDA low |
| pairEn | output | 6 | Per-pair clock output enables from registers 5 and 6 |

## Verification
On every cycle the assertions check four things: the SDA drive moves only while SCL is low, a stop always leaves SDA released, a register changes only in the cycle after a detected SCL falling edge, and the block leaves reset with all enables high and the line free. Other behaviour depends on the content of whole transactions, so only the bench scenarios can show it. This covers address filtering, the discarded preamble, the strict fill order, partial and overflowing writes, the byte count on readback, the silent bus after a host not-acknowledge, and data kept across a repeated start.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

  // Bus events derived from the synchronized pins.
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic sdaBit;
  } busEvt_t;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic shiftIn;
    logic loadTx;
    logic shiftTx;
    logic wrEn;
    logic ptrInc;
    logic ptrClr;
  } dpCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } seqState_t;

endpackage

// File: rtl/cfgbus_dp.sv
module cfgbus_dp
  import cfgbus_pkg::*;
#(
  parameter int NUM_REGS    = 7,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = 4,
  parameter int PRE_BYTES   = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  dpCtl_t                ctl,
  output busEvt_t               evt,
  output logic [7:0]            rxByte,
  output logic                  txBit,
  output logic [IDX_W-1:0]      byteIdx,
  output logic [NUM_REGS*8-1:0] regFlat
);

  localparam logic [IDX_W-1:0] IDX_MAX    = '1;
  localparam logic [7:0]       COUNT_BYTE = 8'(NUM_REGS);

  // Pin synchronizers plus one delay stage for edge detection
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclDly, sdaDly;
  logic sclNow, sdaNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclDly  <= 1'b1;
      sdaDly  <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclDly  <= sclPipe[SYNC_STAGES-1];
      sdaDly  <= sdaPipe[SYNC_STAGES-1];
    end
  end

  assign sclNow       = sclPipe[SYNC_STAGES-1];
  assign sdaNow       = sdaPipe[SYNC_STAGES-1];
  assign evt.sclRise  = sclNow & ~sclDly;
  assign evt.sclFall  = ~sclNow & sclDly;
  assign evt.startDet = sclNow & sclDly & sdaDly & ~sdaNow;
  assign evt.stopDet  = sclNow & sclDly & ~sdaDly & sdaNow;
  assign evt.sdaBit   = sdaNow;

  // Receive shifter
  always_ff @(posedge clk) begin
    if (!rstN) rxByte <= '0;
    else if (ctl.shiftIn) rxByte <= {rxByte[6:0], sdaNow};
  end

  // Byte position within the transfer
  always_ff @(posedge clk) begin
    if (!rstN) byteIdx <= '0;
    else if (ctl.ptrClr) byteIdx <= '0;
    else if ((ctl.ptrInc || ctl.loadTx) && byteIdx != IDX_MAX) byteIdx <= byteIdx + 1'b1;
  end

  // Register file: data byte g sits after the preamble bytes
  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) q <= 8'hFF;
      else if (ctl.wrEn && byteIdx == IDX_W'(g + PRE_BYTES)) q <= rxByte;
    end
    assign regFlat[g*8 +: 8] = q;
  end

  // Transmit byte selection: count first, then registers
  logic [7:0] txNext, txShift;
  always_comb begin
    txNext = 8'hFF;
    if (byteIdx == '0) txNext = COUNT_BYTE;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (byteIdx == IDX_W'(i + 1)) txNext = regFlat[i*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) txShift <= 8'hFF;
    else if (ctl.loadTx) txShift <= txNext;
    else if (ctl.shiftTx) txShift <= {txShift[6:0], 1'b1};
  end

  assign txBit = txShift[7];

endmodule

// File: rtl/cfgbus_ctrl.sv
module cfgbus_ctrl
  import cfgbus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h6A,
  parameter int         NUM_REGS  = 7,
  parameter int         IDX_W     = 4,
  parameter int         PRE_BYTES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  busEvt_t          evt,
  input  logic [7:0]       rxByte,
  input  logic             txBit,
  input  logic [IDX_W-1:0] byteIdx,
  output dpCtl_t           ctl,
  output logic             sdaOe
);

  localparam logic [IDX_W-1:0] WR_LIMIT  = IDX_W'(PRE_BYTES + NUM_REGS);
  localparam logic [3:0]       BYTE_BITS = 4'd8;

  seqState_t  state, stateNx;
  logic [3:0] bitCnt, bitCntNx;
  logic       hostNack, hostNackNx;
  logic       byteDone, bitIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      hostNack <= 1'b0;
    end else begin
      state    <= stateNx;
      bitCnt   <= bitCntNx;
      hostNack <= hostNackNx;
    end
  end

  assign byteDone = evt.sclFall && bitCnt == BYTE_BITS;
  assign bitIn    = evt.sclRise && bitCnt < BYTE_BITS;

  always_comb begin
    stateNx    = state;
    bitCntNx   = bitCnt;
    hostNackNx = hostNack;
    ctl        = '0;
    if (evt.stopDet) begin
      stateNx = ST_IDLE;
    end else if (evt.startDet) begin
      stateNx    = ST_ADDR;
      bitCntNx   = '0;
      ctl.ptrClr = 1'b1;
    end else begin
      case (state)
        ST_ADDR: begin
          if (bitIn) begin
            ctl.shiftIn = 1'b1;
            bitCntNx    = bitCnt + 1'b1;
          end else if (byteDone) begin
            stateNx = (rxByte[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IDLE;
          end
        end
        ST_ADDR_ACK: begin
          if (evt.sclFall) begin
            bitCntNx = '0;
            if (rxByte[0]) begin
              ctl.loadTx = 1'b1;
              stateNx    = ST_RD_BYTE;
            end else begin
              stateNx = ST_WR_BYTE;
            end
          end
        end
        ST_WR_BYTE: begin
          if (bitIn) begin
            ctl.shiftIn = 1'b1;
            bitCntNx    = bitCnt + 1'b1;
          end else if (byteDone) begin
            if (byteIdx < WR_LIMIT) begin
              ctl.wrEn = 1'b1;
              stateNx  = ST_WR_ACK;
            end else begin
              stateNx = ST_IDLE;
            end
          end
        end
        ST_WR_ACK: begin
          if (evt.sclFall) begin
            ctl.ptrInc = 1'b1;
            bitCntNx   = '0;
            stateNx    = ST_WR_BYTE;
          end
        end
        ST_RD_BYTE: begin
          if (bitIn) begin
            bitCntNx = bitCnt + 1'b1;
          end else if (byteDone) begin
            stateNx = ST_RD_ACK;
          end else if (evt.sclFall && bitCnt != '0) begin
            ctl.shiftTx = 1'b1;
          end
        end
        ST_RD_ACK: begin
          if (evt.sclRise) begin
            hostNackNx = evt.sdaBit;
          end else if (evt.sclFall) begin
            if (!hostNack) begin
              ctl.loadTx = 1'b1;
              bitCntNx   = '0;
              stateNx    = ST_RD_BYTE;
            end else begin
              stateNx = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_ADDR_ACK, ST_WR_ACK: sdaOe = 1'b1;
      ST_RD_BYTE:             sdaOe = ~txBit;
      default:                sdaOe = 1'b0;
    endcase
  end

endmodule

// File: rtl/cfgbus_top.sv
module cfgbus_top
  import cfgbus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h6A,
  parameter int         NUM_REGS    = 7,
  parameter int         SYNC_STAGES = 2,
  parameter int         NUM_PAIRS   = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  output logic                 sdaOe,
  output logic [NUM_PAIRS-1:0] pairEn
);

  localparam int PRE_BYTES      = 2;
  localparam int IDX_W          = $clog2(NUM_REGS + PRE_BYTES + 2);
  localparam int EN_BYTE_A      = 5;
  localparam int EN_BYTE_B      = 6;
  localparam int PAIRS_PER_BYTE = NUM_PAIRS / 2;

  busEvt_t               busEvt;
  dpCtl_t                dpCtl;
  logic [7:0]            rxByte;
  logic                  txBit;
  logic [IDX_W-1:0]      byteIdx;
  logic [NUM_REGS*8-1:0] regFlat;
  logic                  stopSeen, fallSeen;

  cfgbus_dp #(
    .NUM_REGS(NUM_REGS), .SYNC_STAGES(SYNC_STAGES), .IDX_W(IDX_W), .PRE_BYTES(PRE_BYTES)
  ) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(dpCtl),
    .evt(busEvt), .rxByte(rxByte), .txBit(txBit), .byteIdx(byteIdx), .regFlat(regFlat)
  );

  cfgbus_ctrl #(
    .DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .PRE_BYTES(PRE_BYTES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .evt(busEvt), .rxByte(rxByte), .txBit(txBit),
    .byteIdx(byteIdx), .ctl(dpCtl), .sdaOe(sdaOe)
  );

  for (genvar k = 0; k < PAIRS_PER_BYTE; k++) begin : gPair
    assign pairEn[k]                  = regFlat[EN_BYTE_A*8 + k];
    assign pairEn[PAIRS_PER_BYTE + k] = regFlat[EN_BYTE_B*8 + k];
  end

  assign stopSeen = busEvt.stopDet;
  assign fallSeen = busEvt.sclFall;

endmodule

// File: rtl/cfgbus_chk.sv
module cfgbus_chk #(
  parameter int NUM_REGS  = 7,
  parameter int NUM_PAIRS = 6
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclIn,
  input logic                  sdaOe,
  input logic [NUM_PAIRS-1:0]  pairEn,
  input logic                  stopSeen,
  input logic                  fallSeen,
  input logic [NUM_REGS*8-1:0] regFlat
);

  AST_RESET_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pairEn == '1 && !sdaOe)); // R8

  AST_SDA_LOW_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn); // R11

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaOe); // R7

  AST_REG_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regFlat) |-> $past(fallSeen)); // R4

endmodule

bind cfgbus_top cfgbus_chk #(.NUM_REGS(NUM_REGS), .NUM_PAIRS(NUM_PAIRS)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe), .pairEn(pairEn),
  .stopSeen(stopSeen), .fallSeen(fallSeen), .regFlat(regFlat)
);

// File: tb/sim_cfgbus_top.sv
module sim_cfgbus_top;
  localparam int CLK_PER = 10;
  localparam int Q       = 8;
  localparam int NREG    = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic mLow = 1'b0;
  logic sdaIn;
  logic sdaOe;
  logic [5:0] pairEn;

  assign sdaIn = ~(mLow | sdaOe);
  always #(CLK_PER/2) clk = ~clk;

  cfgbus_top u0 (.clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaIn), .sdaOe(sdaOe), .pairEn(pairEn));

  int total = 0;
  int bad = 0;
  int edgeViol = 0;
  bit done = 0;
  logic prevOe = 1'b0;
  logic [7:0] model [NREG];
  logic [7:0] wbuf [9];

  // R11 monitor: drive may only move while SCL is low
  always @(negedge clk) begin
    if (rstN && sdaOe !== prevOe && sclDrv) edgeViol++;
    prevOe = sdaOe;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic busStart();
    mLow = 1'b0; tick(Q);
    sclDrv = 1'b1; tick(Q);
    mLow = 1'b1; tick(Q);
    sclDrv = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    mLow = 1'b1; tick(Q);
    sclDrv = 1'b1; tick(Q);
    mLow = 1'b0; tick(Q);
  endtask

  task automatic sendBit(input logic b);
    mLow = ~b; tick(Q);
    sclDrv = 1'b1; tick(2*Q);
    sclDrv = 1'b0; tick(Q);
  endtask

  task automatic recvBit(output logic b);
    mLow = 1'b0; tick(Q);
    sclDrv = 1'b1; tick(Q);
    b = sdaIn; tick(Q);
    sclDrv = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(b);
    ack = ~b;
  endtask

  task automatic recvByte(output logic [7:0] v, input logic doAck);
    logic b;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      recvBit(b);
      v = {v[6:0], b};
    end
    sendBit(~doAck);
  endtask

  function automatic int expPair();
    return int'({model[6][2:0], model[5][2:0]});
  endfunction

  task automatic writeTx(input logic [7:0] addrByte, input logic [7:0] cmd,
                         input logic [7:0] cnt, input int n, input bit keepOpen);
    logic a;
    busStart();
    sendByte(addrByte, a);
    if (addrByte[7:1] != 7'h6A) begin
      chk("R1 foreign address not acked", int'(a), 0);
      busStop();
      return;
    end
    chk("R1 write address acked", int'(a), 1);
    sendByte(cmd, a);
    chk("R2 command byte acked", int'(a), 1);
    sendByte(cnt, a);
    chk("R2 count byte acked", int'(a), 1);
    for (int i = 0; i < n; i++) begin
      sendByte(wbuf[i], a);
      if (i < NREG) begin
        chk("R3 data byte acked", int'(a), 1);
        model[i] = wbuf[i];
      end else begin
        chk("R5 overflow byte not acked", int'(a), 0);
      end
    end
    if (!keepOpen) busStop();
  endtask

  task automatic readTx(input int n, input int extraBits, input string tag);
    logic a;
    logic b;
    logic [7:0] v;
    busStart();
    sendByte(8'hD5, a);
    chk("R1 read address acked", int'(a), 1);
    recvByte(v, n > 0);
    chk("R6 byte count", int'(v), NREG);
    for (int i = 0; i < n; i++) begin
      recvByte(v, i < n - 1);
      chk(tag, int'(v), int'(model[i]));
    end
    for (int e = 0; e < extraBits; e++) begin
      recvBit(b);
      chk("R7 SDA released after host nack", int'(b), 1);
    end
    busStop();
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = 8'hFF;
    tick(5);
    rstN = 1'b1;
    tick(4);
    chk("R8 pair enables after reset", int'(pairEn), 6'h3F);
    chk("R8 SDA released after reset", int'(sdaOe), 0);
    readTx(NREG, 0, "R8 R6 reset register value");
    chk("R9 pair enable mapping", int'(pairEn), expPair());

    // R1: every single-bit corruption of the address, both directions
    for (int k = 1; k < 8; k++) begin
      for (int rw = 0; rw < 2; rw++) begin
        writeTx((8'hD4 ^ 8'(1 << k)) | 8'(rw), 8'h00, 8'h00, 0, 1'b0);
      end
    end
    readTx(NREG, 0, "R1 registers untouched by foreign address");

    // R2 R3 R4 R5: write lengths 0..8 with varying preamble values
    for (int n = 0; n <= 8; n++) begin
      for (int i = 0; i < 9; i++) wbuf[i] = 8'(n*29 + i*53 + 7);
      writeTx(8'hD4, 8'(n*17 + 3), 8'(~n), n, 1'b0);
      readTx(NREG, 0, "R2 R3 R4 R5 register after partial write");
      chk("R9 pair enable mapping", int'(pairEn), expPair());
    end

    // R7: host ends read early, then clocks the bus with SDA released
    readTx(3, 9, "R7 R6 short read byte");
    readTx(NREG, 0, "R7 full read after early nack");

    // R10: repeated start right after two data bytes
    wbuf[0] = 8'h5A;
    wbuf[1] = 8'hC3;
    writeTx(8'hD4, 8'hEE, 8'h11, 2, 1'b1);
    readTx(NREG, 0, "R10 register after repeated start");
    chk("R9 pair enable mapping", int'(pairEn), expPair());

    chk("R11 SDA drive moved while SCL high", edgeViol, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule